// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block holds the coherence state of every line in a small private cache that watches a shared bus and uses invalidation. Each cycle it can take one event from the local core side: a read, a write or an eviction of a line. In the same cycle it can also take one event snooped from the bus: a read, a write or an upgrade by another cache. From the stored state of each addressed line it works out the next state. It also raises the actions that go with the transition: a bus read, a bus write or a bus upgrade to issue, a shared or dirty response to the snoop, a writeback of line data, or a protocol error.

All actions are combinational, so they are valid in the cycle the event is presented. The new state is stored at the next rising clock edge. On a local read miss, the "shared" wire that other caches drive during the bus read is sampled in that same cycle. It decides whether the fill lands in Exclusive or Shared. A combinational lookup port returns the stored state of any line, so the tag pipeline can tell a hit from a miss. Tag compare, data storage and bus arbitration sit outside the block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: State codes are Invalid=00, Shared=01, Exclusive=10, Modified=11. After reset every line holds Invalid. The lookup port returns the stored state of `look_idx` combinationally.
- R2: A local read (op 0) to an Invalid line raises `bus_rd`. The line becomes Exclusive when `fill_shared` is low in that cycle, and Shared when it is high.
- R3: A local write (op 1) to an Invalid line raises `bus_wr`, and the line becomes Modified. A local eviction (op 2) or any snooped event to an Invalid line raises nothing, and the line stays Invalid.
- R4: For a Shared line:
  - a local write raises `bus_upg` and the line becomes Modified;
  - an eviction makes it Invalid with no writeback;
  - a snooped read (op 0) raises `snp_resp_shared` and the line stays Shared;
  - a snooped write (op 1) or snooped upgrade (op 2) makes it Invalid.
- R5: For an Exclusive line:
  - a local write makes it Modified with no bus command;
  - an eviction makes it Invalid;
  - a snooped read raises `snp_resp_shared` and the line becomes Shared;
  - a snooped write makes it Invalid.
- R6: A local eviction of a Modified line raises `loc_wb`, and the line becomes Invalid.
- R7: For a Modified line:
  - a snooped read raises `snp_resp_dirty` and `snp_wb`, and the line becomes Shared;
  - a snooped write raises the same two outputs, and the line becomes Invalid.
- R8: A snooped upgrade to an Exclusive or Modified line raises `proto_err`, and the line keeps its state.
- R9: A local read to a Shared, Exclusive or Modified line raises no bus command and leaves the state unchanged. A local write to a Modified line does the same.
- R10: When a snoop and a local event address the same line in one cycle, the snoop is applied first. The local event is then evaluated against the state the snoop produced. The outputs of both are raised together, and the stored result is the local event's next state.
- R11: Events to one line never change another line. A snoop and a local event to different lines in the same cycle both take effect.
- R12: An event whose valid is low, and an event with op code 3, raise no output and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_valid | input | 1 | Local event present |
| loc_op | input | 2 | Local event: 0 read, 1 write, 2 evict, 3 none |
| loc_idx | input | IDX_W | Line addressed by the local event |
| fill_shared | input | 1 | Another cache holds the line; sampled with `bus_rd` |
| snp_valid | input | 1 | Snooped event present |
| snp_op | input | 2 | Snooped event: 0 bus read, 1 bus write, 2 bus upgrade, 3 none |
| snp_idx | input | IDX_W | Line addressed by the snoop |
| look_idx | input | IDX_W | Line to look up |
| look_state | output | 2 | Stored state of `look_idx` |
| bus_rd | output | 1 | Issue a bus read |
| bus_wr | output | 1 | Issue a bus write |
| bus_upg | output | 1 | Issue a bus upgrade |
| snp_resp_shared | output | 1 | Respond shared to the snoop |
| snp_resp_dirty | output | 1 | Respond dirty to the snoop |
| snp_wb | output | 1 | Write the snooped line back |
| loc_wb | output | 1 | Write the evicted line back |
| proto_err | output | 1 | Snooped upgrade hit an exclusively held line |

## Verification
A snoop and a local event can land in the same cycle. The interesting case is when both carry the same line index, so the local transition has to use the post-snoop state.

The bench provokes this case three ways:
- a snooped read of a Modified line together with a local write, expecting a dirty response, a writeback and an upgrade, with the line ending in Modified;
- a snooped write of a Modified line together with a local read, expecting a writeback and a bus read, with the line refilled as Exclusive;
- a snooped read of an Exclusive line together with an eviction.

A separate case sends the two events to different lines, and both must take effect.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_t;

  typedef enum logic [1:0] {
    LOC_RD    = 2'd0,
    LOC_WR    = 2'd1,
    LOC_EVICT = 2'd2,
    LOC_NOP   = 2'd3
  } loc_op_t;

  typedef enum logic [1:0] {
    SNP_RD  = 2'd0,
    SNP_WR  = 2'd1,
    SNP_UPG = 2'd2,
    SNP_NOP = 2'd3
  } snp_op_t;

  // actions raised by the local-side transition
  typedef struct packed {
    logic bus_rd;
    logic bus_wr;
    logic bus_upg;
    logic wb;
  } loc_act_t;

  // actions raised by the snoop-side transition
  typedef struct packed {
    logic resp_sh;
    logic resp_dirty;
    logic wb;
    logic err;
  } snp_act_t;

endpackage

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
  import mesi_pkg::*;
(
  input  logic     valid,
  input  snp_op_t  op,
  input  line_st_t cur,
  output line_st_t nxt,
  output snp_act_t act
);

  always_comb begin
    nxt = cur;
    act = '0;
    if (valid) begin
      case (cur)
        ST_S: begin
          case (op)
            SNP_RD:  act.resp_sh = 1'b1;
            SNP_WR:  nxt = ST_I;
            SNP_UPG: nxt = ST_I;
            default: nxt = cur;
          endcase
        end
        ST_E: begin
          case (op)
            SNP_RD: begin
              act.resp_sh = 1'b1;
              nxt = ST_S;
            end
            SNP_WR:  nxt = ST_I;
            SNP_UPG: act.err = 1'b1;
            default: nxt = cur;
          endcase
        end
        ST_M: begin
          case (op)
            SNP_RD: begin
              act.resp_dirty = 1'b1;
              act.wb = 1'b1;
              nxt = ST_S;
            end
            SNP_WR: begin
              act.resp_dirty = 1'b1;
              act.wb = 1'b1;
              nxt = ST_I;
            end
            SNP_UPG: act.err = 1'b1;
            default: nxt = cur;
          endcase
        end
        default: nxt = cur;
      endcase
    end
  end

endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
  import mesi_pkg::*;
(
  input  logic     valid,
  input  loc_op_t  op,
  input  line_st_t cur,
  input  logic     shared_in,
  output line_st_t nxt,
  output loc_act_t act
);

  always_comb begin
    nxt = cur;
    act = '0;
    if (valid) begin
      case (cur)
        ST_I: begin
          case (op)
            LOC_RD: begin
              act.bus_rd = 1'b1;
              nxt = shared_in ? ST_S : ST_E;
            end
            LOC_WR: begin
              act.bus_wr = 1'b1;
              nxt = ST_M;
            end
            default: nxt = cur;
          endcase
        end
        ST_S: begin
          case (op)
            LOC_WR: begin
              act.bus_upg = 1'b1;
              nxt = ST_M;
            end
            LOC_EVICT: nxt = ST_I;
            default:   nxt = cur;
          endcase
        end
        ST_E: begin
          case (op)
            LOC_WR:    nxt = ST_M;
            LOC_EVICT: nxt = ST_I;
            default:   nxt = cur;
          endcase
        end
        default: begin
          if (op == LOC_EVICT) begin
            act.wb = 1'b1;
            nxt = ST_I;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_snp_idx,
  output line_st_t         rd_snp_st,
  input  logic [IDX_W-1:0] rd_loc_idx,
  output line_st_t         rd_loc_st,
  input  logic [IDX_W-1:0] rd_look_idx,
  output line_st_t         rd_look_st,
  // write port A has priority over port B on the same line
  input  logic             wa_en,
  input  logic [IDX_W-1:0] wa_idx,
  input  line_st_t         wa_st,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  line_st_t         wb_st
);

  localparam int SLOTS = 1 << IDX_W;

  line_st_t st_q [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_line
    if (g < NUM_LINES) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          st_q[g] <= ST_I;
        else if (wa_en && (wa_idx == IDX_W'(g)))
          st_q[g] <= wa_st;
        else if (wb_en && (wb_idx == IDX_W'(g)))
          st_q[g] <= wb_st;
      end
    end else begin : g_pad
      assign st_q[g] = ST_I;
    end
  end

  assign rd_snp_st  = st_q[rd_snp_idx];
  assign rd_loc_st  = st_q[rd_loc_idx];
  assign rd_look_st = st_q[rd_look_idx];

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_valid,
  input  logic [1:0]       loc_op,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic             fill_shared,
  input  logic             snp_valid,
  input  logic [1:0]       snp_op,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       look_state,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_upg,
  output logic             snp_resp_shared,
  output logic             snp_resp_dirty,
  output logic             snp_wb,
  output logic             loc_wb,
  output logic             proto_err
);

  line_st_t snp_cur, snp_nxt;
  line_st_t loc_stored, loc_cur, loc_nxt;
  line_st_t look_st;
  snp_act_t snp_act;
  loc_act_t loc_act;
  logic     same_line;

  mesi_state_array #(.NUM_LINES(NUM_LINES)) u_arr (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_snp_idx  (snp_idx),
    .rd_snp_st   (snp_cur),
    .rd_loc_idx  (loc_idx),
    .rd_loc_st   (loc_stored),
    .rd_look_idx (look_idx),
    .rd_look_st  (look_st),
    .wa_en       (loc_valid),
    .wa_idx      (loc_idx),
    .wa_st       (loc_nxt),
    .wb_en       (snp_valid),
    .wb_idx      (snp_idx),
    .wb_st       (snp_nxt)
  );

  mesi_snoop_fsm u_snp (
    .valid (snp_valid),
    .op    (snp_op_t'(snp_op)),
    .cur   (snp_cur),
    .nxt   (snp_nxt),
    .act   (snp_act)
  );

  // snoop is ordered ahead of the local event on a shared line
  assign same_line = snp_valid && (snp_idx == loc_idx);
  assign loc_cur   = same_line ? snp_nxt : loc_stored;

  mesi_local_fsm u_loc (
    .valid     (loc_valid),
    .op        (loc_op_t'(loc_op)),
    .cur       (loc_cur),
    .shared_in (fill_shared),
    .nxt       (loc_nxt),
    .act       (loc_act)
  );

  assign look_state      = look_st;
  assign bus_rd          = loc_act.bus_rd;
  assign bus_wr          = loc_act.bus_wr;
  assign bus_upg         = loc_act.bus_upg;
  assign loc_wb          = loc_act.wb;
  assign snp_resp_shared = snp_act.resp_sh;
  assign snp_resp_dirty  = snp_act.resp_dirty;
  assign snp_wb          = snp_act.wb;
  assign proto_err       = snp_act.err;

endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loc_valid,
  input logic [1:0] loc_op,
  input logic       snp_valid,
  input logic [1:0] snp_op,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       bus_upg,
  input logic       snp_resp_shared,
  input logic       snp_resp_dirty,
  input logic       snp_wb,
  input logic       loc_wb,
  input logic       proto_err
);

  // R9
  bus_cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr, bus_upg}));

  // R2
  bus_rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (loc_valid && loc_op == 2'd0));

  // R3
  bus_wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (loc_valid && loc_op == 2'd1));

  // R6
  loc_wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wb |-> (loc_valid && loc_op == 2'd2));

  // R7
  dirty_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_resp_dirty |-> (snp_wb && !snp_resp_shared));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (snp_valid && snp_op == 2'd2 && !snp_resp_dirty && !snp_resp_shared));

  // R12
  idle_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_valid || snp_op == 2'd3) |-> !(snp_resp_shared || snp_resp_dirty || snp_wb || proto_err));

  // R12
  idle_local_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_valid || loc_op == 2'd3) |-> !(bus_rd || bus_wr || bus_upg || loc_wb));

endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .loc_valid       (loc_valid),
  .loc_op          (loc_op),
  .snp_valid       (snp_valid),
  .snp_op          (snp_op),
  .bus_rd          (bus_rd),
  .bus_wr          (bus_wr),
  .bus_upg         (bus_upg),
  .snp_resp_shared (snp_resp_shared),
  .snp_resp_dirty  (snp_resp_dirty),
  .snp_wb          (snp_wb),
  .loc_wb          (loc_wb),
  .proto_err       (proto_err)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;

  localparam int NL = 8;
  localparam int IW = 3;

  // action bits: {bus_rd,bus_wr,bus_upg,resp_sh,resp_dirty,snp_wb,loc_wb,err}
  localparam logic [7:0] A_BRD = 8'h80, A_BWR = 8'h40, A_UPG = 8'h20,
                         A_RSH = 8'h10, A_RDY = 8'h08, A_SWB = 8'h04,
                         A_LWB = 8'h02, A_ERR = 8'h01, A_NONE = 8'h00;
  localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
  localparam logic [1:0] LRD = 2'd0, LWR = 2'd1, LEV = 2'd2;
  localparam logic [1:0] BRD = 2'd0, BWR = 2'd1, BUP = 2'd2, NOP = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_valid = 1'b0, snp_valid = 1'b0, fill_shared = 1'b0;
  logic [1:0] loc_op = 2'd0, snp_op = 2'd0;
  logic [IW-1:0] loc_idx = '0, snp_idx = '0, look_idx = '0;
  logic [1:0] look_state;
  logic bus_rd, bus_wr, bus_upg, snp_resp_shared, snp_resp_dirty, snp_wb, loc_wb, proto_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] act;

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_valid(loc_valid), .loc_op(loc_op), .loc_idx(loc_idx), .fill_shared(fill_shared),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
    .look_idx(look_idx), .look_state(look_state),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_upg(bus_upg),
    .snp_resp_shared(snp_resp_shared), .snp_resp_dirty(snp_resp_dirty),
    .snp_wb(snp_wb), .loc_wb(loc_wb), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // present one cycle of events; act holds the outputs seen before the edge
  task automatic ev(input logic lv, input logic [1:0] lop, input int li,
                    input logic sv, input logic [1:0] sop, input int si, input logic sh);
    @(negedge clk);
    loc_valid = lv; loc_op = lop; loc_idx = IW'(li);
    snp_valid = sv; snp_op = sop; snp_idx = IW'(si); fill_shared = sh;
    #1;
    act = {bus_rd, bus_wr, bus_upg, snp_resp_shared, snp_resp_dirty, snp_wb, loc_wb, proto_err};
    @(posedge clk);
    #1;
    loc_valid = 1'b0; snp_valid = 1'b0; fill_shared = 1'b0;
  endtask

  task automatic st_chk(input string req, input int idx, input logic [1:0] exp);
    look_idx = IW'(idx);
    #1;
    chk(req, {6'd0, look_state}, {6'd0, exp});
  endtask

  task automatic loc_ev(input string req, input logic [1:0] op, input int li, input logic sh,
                        input logic [7:0] exp_act, input logic [1:0] exp_st);
    ev(1'b1, op, li, 1'b0, NOP, 0, sh);
    chk(req, act, exp_act);
    st_chk(req, li, exp_st);
  endtask

  task automatic snp_ev(input string req, input logic [1:0] op, input int si,
                        input logic [7:0] exp_act, input logic [1:0] exp_st);
    ev(1'b0, LRD, 0, 1'b1, op, si, 1'b0);
    chk(req, act, exp_act);
    st_chk(req, si, exp_st);
  endtask

  // bring a line to a given state through the local interface
  task automatic mk(input int idx, input logic [1:0] st);
    ev(1'b1, LEV, idx, 1'b0, NOP, 0, 1'b0);
    case (st)
      S: ev(1'b1, LRD, idx, 1'b0, NOP, 0, 1'b1);
      E: ev(1'b1, LRD, idx, 1'b0, NOP, 0, 1'b0);
      M: ev(1'b1, LWR, idx, 1'b0, NOP, 0, 1'b0);
      default: ;
    endcase
  endtask

  task automatic t_reset;
    for (int k = 0; k < NL; k++) st_chk("R1 reset", k, I);
  endtask

  task automatic t_invalid;
    loc_ev("R2 fill excl", LRD, 0, 1'b0, A_BRD, E);
    loc_ev("R2 fill shared", LRD, 1, 1'b1, A_BRD, S);
    loc_ev("R3 write miss", LWR, 2, 1'b0, A_BWR, M);
    loc_ev("R3 evict in I", LEV, 3, 1'b0, A_NONE, I);
    snp_ev("R3 snoop rd in I", BRD, 3, A_NONE, I);
    snp_ev("R3 snoop wr in I", BWR, 3, A_NONE, I);
    snp_ev("R3 snoop upg in I", BUP, 3, A_NONE, I);
  endtask

  task automatic t_shared;
    mk(4, S);
    loc_ev("R9 read hit S", LRD, 4, 1'b0, A_NONE, S);
    snp_ev("R4 snoop rd S", BRD, 4, A_RSH, S);
    loc_ev("R4 write S", LWR, 4, 1'b0, A_UPG, M);
    mk(4, S);
    snp_ev("R4 snoop wr S", BWR, 4, A_NONE, I);
    mk(4, S);
    snp_ev("R4 snoop upg S", BUP, 4, A_NONE, I);
    mk(4, S);
    loc_ev("R4 evict S", LEV, 4, 1'b0, A_NONE, I);
  endtask

  task automatic t_excl;
    mk(5, E);
    loc_ev("R9 read hit E", LRD, 5, 1'b0, A_NONE, E);
    snp_ev("R8 upg in E", BUP, 5, A_ERR, E);
    loc_ev("R5 silent E->M", LWR, 5, 1'b0, A_NONE, M);
    mk(5, E);
    snp_ev("R5 snoop rd E", BRD, 5, A_RSH, S);
    mk(5, E);
    snp_ev("R5 snoop wr E", BWR, 5, A_NONE, I);
    mk(5, E);
    loc_ev("R5 evict E", LEV, 5, 1'b0, A_NONE, I);
  endtask

  task automatic t_mod;
    mk(6, M);
    loc_ev("R9 read hit M", LRD, 6, 1'b0, A_NONE, M);
    loc_ev("R9 write hit M", LWR, 6, 1'b0, A_NONE, M);
    snp_ev("R8 upg in M", BUP, 6, A_ERR, M);
    snp_ev("R7 snoop rd M", BRD, 6, A_RDY | A_SWB, S);
    mk(6, M);
    snp_ev("R7 snoop wr M", BWR, 6, A_RDY | A_SWB, I);
    mk(6, M);
    loc_ev("R6 evict M", LEV, 6, 1'b0, A_LWB, I);
  endtask

  task automatic t_same;
    mk(7, M);
    ev(1'b1, LWR, 7, 1'b1, BRD, 7, 1'b0);
    chk("R10 M snoop rd + write", act, A_RDY | A_SWB | A_UPG);
    st_chk("R10 M snoop rd + write", 7, M);
    ev(1'b1, LRD, 7, 1'b1, BWR, 7, 1'b0);
    chk("R10 M snoop wr + read", act, A_RDY | A_SWB | A_BRD);
    st_chk("R10 M snoop wr + read", 7, E);
    ev(1'b1, LEV, 7, 1'b1, BRD, 7, 1'b0);
    chk("R10 E snoop rd + evict", act, A_RSH);
    st_chk("R10 E snoop rd + evict", 7, I);
  endtask

  task automatic t_indep;
    mk(1, E);
    mk(2, M);
    mk(3, S);
    ev(1'b1, LEV, 2, 1'b1, BWR, 1, 1'b0);
    chk("R11 split lines", act, A_LWB);
    st_chk("R11 snoop line", 1, I);
    st_chk("R11 local line", 2, I);
    st_chk("R11 bystander", 3, S);
  endtask

  task automatic t_ignore;
    mk(0, M);
    ev(1'b1, NOP, 0, 1'b1, NOP, 0, 1'b0);
    chk("R12 op3", act, A_NONE);
    st_chk("R12 op3", 0, M);
    ev(1'b0, LEV, 0, 1'b0, BWR, 0, 1'b0);
    chk("R12 valid low", act, A_NONE);
    st_chk("R12 valid low", 0, M);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_invalid;
    t_shared;
    t_excl;
    t_mod;
    t_same;
    t_indep;
    t_ignore;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule